// File: doc/BRIEF.md
# Serial Memory Bus Target Controller

This block is the bus-facing state machine of a two-wire serial memory. A fast system clock samples the bus clock and data lines. From these samples the block finds start, repeated start and stop conditions, collects the target address byte, a two-byte memory address and write data, and answers each byte with an acknowledge or a refusal. During reads it pulls the shared data line low for zero bits and releases it for one bits.

The block holds no memory array of its own. It drives single-cycle strobes to three neighbours:
- an address pointer, which it can load or advance;
- a write buffer, which receives each accepted byte and a commit strobe when the transfer ends;
- a protection checker, which tells it whether the location under the pointer is read-only.

A busy input from the write engine makes the block ignore its own address, so a bus master can poll until the internal write finishes.

Top module: `i2c_mem_target`

## Requirements
- R1: A start condition is data falling while the bus clock is high; a stop is data rising while the bus clock is high. A start in any state, including partway through a byte, restarts reception at the target address byte. A stop returns the block to idle, where it ignores bus clocks until the next start.
- R2: The data-line pull-down output changes only while the sampled bus clock is low, except when it is released on a start or stop.
- R3: The target address byte is the 7-bit value 1010001 (sent MSB first) followed by a direction bit, where 1 is read and 0 is write. A non-matching address is not acknowledged, and the block does not pull the data line for the rest of that transfer.
- R4: While `busy_i` is high, the block does not acknowledge its own address for either direction.
- R5: In a write transfer, both address bytes are acknowledged. After the second one, the block pulses `ptr_load_o` with {high byte, low byte}, with bit 14 forced to 0 and bit 15 passed through. Bit 15 = 1 selects the protect register.
- R6: Each data byte written to an unprotected location is acknowledged. In the same cycle, the block pulses `wr_strobe_o` with the byte on `wr_data_o` and pulses `ptr_inc_o`.
- R7: A data byte received while `prot_hit_i` is high is not acknowledged. It produces neither `wr_strobe_o` nor `ptr_inc_o`.
- R8: A stop that ends a write with at least one accepted data byte pulses `wr_commit_o` once. A stop after no accepted data, or a repeated start, produces no commit.
- R9: After acknowledging a read address, the block sends `rd_data_i` MSB first. Each bit changes after a bus clock falling edge. The block releases the data line for the ninth clock and pulses `ptr_inc_o` once per byte sent.
- R10: When the master acknowledges, the block sends the next byte. After a refusal from the master, the block releases the line and ignores further clocks until a start.
- R11: A read address with no address phase returns data at the current pointer. A write address, two address bytes, a repeated start and a read address load the pointer first and then read from the loaded location.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin (wired level) |
| sda_low_o | output | 1 | 1 pulls the data line low; 0 releases it |
| busy_i | input | 1 | Internal write cycle in progress |
| prot_hit_i | input | 1 | Location under the pointer is write-protected |
| rd_data_i | input | 8 | Byte stored at the current pointer |
| ptr_load_o | output | 1 | Load the pointer from `ptr_addr_o` |
| ptr_addr_o | output | 16 | Address to load, bit 14 cleared |
| ptr_inc_o | output | 1 | Advance the pointer by one |
| wr_strobe_o | output | 1 | Accepted write byte is valid on `wr_data_o` |
| wr_data_o | output | 8 | Write byte |
| wr_commit_o | output | 1 | Start the internal write cycle |

## Verification
The bench uses the default parameters: a two-stage synchronizer and target address 1010001. A quarter bus bit lasts eight system clocks, so each sampled edge and each driven bit settles well inside one bus phase. Under these settings, refusals can be observed directly on the wired data line, read by the bench's model master. This covers protected bytes, busy polling and wrong addresses. Page writes, sequential and immediate reads, and aborted bytes run against a small behavioural pointer and memory that the bench keeps itself.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int ADDR_W  = 16;
    localparam int SEL_BIT = ADDR_W - 1;
    localparam int IGN_BIT = ADDR_W - 2;

    localparam logic [3:0] CNT_EVAL = 4'd8;
    localparam logic [3:0] CNT_ACK  = 4'd9;
    localparam logic [3:0] CNT_DONE = 4'd10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_RDAT
    } tgt_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic addr_match(input logic [7:0] b, input logic [6:0] dev);
        return b[7:1] == dev;
    endfunction

endpackage

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic             scl_d, sda_d;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_sync
        logic [SYNC_STAGES-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) q <= '1;
            else     q <= {q[SYNC_STAGES-2:0], raw[g]};
        end
        assign synced[g] = q[SYNC_STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= synced[1];
            sda_d <= synced[0];
        end
    end

    always_comb begin
        ev.scl      = synced[1];
        ev.sda      = synced[0];
        ev.scl_rise = synced[1] && !scl_d;
        ev.scl_fall = !synced[1] && scl_d;
        ev.start    = synced[1] && scl_d && sda_d && !synced[0];
        ev.stop     = synced[1] && scl_d && !sda_d && synced[0];
    end

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1010001
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic              busy,
    input  logic              prot_hit,
    input  logic [7:0]        rd_data,
    output logic              sda_low,
    output logic              ptr_load,
    output logic [ADDR_W-1:0] ptr_addr,
    output logic              ptr_inc,
    output logic              wr_strobe,
    output logic [7:0]        wr_data,
    output logic              wr_commit
);

    tgt_state_e state, nxt;
    logic [3:0] cnt;
    logic [7:0] shreg, tx, hi;
    logic       mack, wr_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            nxt       <= ST_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            tx        <= '0;
            hi        <= '0;
            mack      <= 1'b0;
            wr_pend   <= 1'b0;
            sda_low   <= 1'b0;
            ptr_load  <= 1'b0;
            ptr_addr  <= '0;
            ptr_inc   <= 1'b0;
            wr_strobe <= 1'b0;
            wr_data   <= '0;
            wr_commit <= 1'b0;
        end else begin
            ptr_load  <= 1'b0;
            ptr_inc   <= 1'b0;
            wr_strobe <= 1'b0;
            wr_commit <= 1'b0;
            if (ev.start) begin
                state   <= ST_DEV;
                cnt     <= '0;
                sda_low <= 1'b0;
                wr_pend <= 1'b0;
            end else if (ev.stop) begin
                wr_commit <= (state == ST_WDAT) && wr_pend;
                state     <= ST_IDLE;
                cnt       <= '0;
                sda_low   <= 1'b0;
                wr_pend   <= 1'b0;
            end else if (state == ST_RDAT) begin
                if (ev.scl_rise) begin
                    if (cnt < CNT_EVAL) cnt <= cnt + 4'd1;
                    else if (cnt == CNT_ACK) begin
                        mack <= !ev.sda;
                        cnt  <= CNT_DONE;
                    end
                end else if (ev.scl_fall) begin
                    if (cnt != 4'd0 && cnt < CNT_EVAL) begin
                        sda_low <= !tx[6];
                        tx      <= {tx[6:0], 1'b0};
                    end else if (cnt == CNT_EVAL) begin
                        sda_low <= 1'b0;
                        ptr_inc <= 1'b1;
                        cnt     <= CNT_ACK;
                    end else if (cnt == CNT_DONE) begin
                        cnt <= '0;
                        if (mack) begin
                            tx      <= rd_data;
                            sda_low <= !rd_data[7];
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
            end else if (state != ST_IDLE) begin
                if (ev.scl_rise) begin
                    if (cnt < CNT_EVAL) begin
                        shreg <= {shreg[6:0], ev.sda};
                        cnt   <= cnt + 4'd1;
                    end else if (cnt == CNT_ACK) begin
                        cnt <= CNT_DONE;
                    end
                end else if (ev.scl_fall) begin
                    if (cnt == CNT_EVAL) begin
                        cnt <= CNT_ACK;
                        unique case (state)
                            ST_DEV: begin
                                if (addr_match(shreg, DEV_ADDR) && !busy) begin
                                    sda_low <= 1'b1;
                                    nxt     <= shreg[0] ? ST_RDAT : ST_AHI;
                                end else begin
                                    nxt <= ST_IDLE;
                                end
                            end
                            ST_AHI: begin
                                sda_low <= 1'b1;
                                hi      <= shreg;
                                nxt     <= ST_ALO;
                            end
                            ST_ALO: begin
                                sda_low  <= 1'b1;
                                ptr_load <= 1'b1;
                                ptr_addr <= {hi, shreg} & ~(ADDR_W'(1) << IGN_BIT);
                                nxt      <= ST_WDAT;
                            end
                            default: begin
                                nxt <= ST_WDAT;
                                if (!prot_hit) begin
                                    sda_low   <= 1'b1;
                                    wr_strobe <= 1'b1;
                                    wr_data   <= shreg;
                                    ptr_inc   <= 1'b1;
                                    wr_pend   <= 1'b1;
                                end
                            end
                        endcase
                    end else if (cnt == CNT_DONE) begin
                        cnt   <= '0;
                        state <= nxt;
                        if (nxt == ST_RDAT) begin
                            tx      <= rd_data;
                            sda_low <= !rd_data[7];
                        end else begin
                            sda_low <= 1'b0;
                        end
                    end
                end
            end
        end
    end

    p_sda_scl_low_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_low) |-> (!$past(ev.scl) || $past(ev.start) || $past(ev.stop)));

    p_busy_nack_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DEV && cnt == CNT_EVAL && ev.scl_fall && busy && !ev.start && !ev.stop)
        |=> !sda_low);

    p_a14_clear_r5: assert property (@(posedge clk) disable iff (rst)
        ptr_load |-> !ptr_addr[IGN_BIT]);

    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ptr_load, ptr_inc, wr_commit}));

    p_prot_block_r7: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> !$past(prot_hit));

    p_commit_stop_r8: assert property (@(posedge clk) disable iff (rst)
        wr_commit |-> $past(ev.stop));

endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
    import i2c_tgt_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = 7'b1010001
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_low_o,
    input  logic        busy_i,
    input  logic        prot_hit_i,
    input  logic [7:0]  rd_data_i,
    output logic        ptr_load_o,
    output logic [15:0] ptr_addr_o,
    output logic        ptr_inc_o,
    output logic        wr_strobe_o,
    output logic [7:0]  wr_data_o,
    output logic        wr_commit_o
);

    bus_ev_t ev;

    i2c_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_target_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .busy      (busy_i),
        .prot_hit  (prot_hit_i),
        .rd_data   (rd_data_i),
        .sda_low   (sda_low_o),
        .ptr_load  (ptr_load_o),
        .ptr_addr  (ptr_addr_o),
        .ptr_inc   (ptr_inc_o),
        .wr_strobe (wr_strobe_o),
        .wr_data   (wr_data_o),
        .wr_commit (wr_commit_o)
    );

endmodule

// File: tb/i2c_mem_target_tb.sv
module i2c_mem_target_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic        m_scl = 1'b1, m_sda = 1'b1;
    logic        sda_low, busy = 1'b0, prot_on = 1'b0;
    logic        ptr_load, ptr_inc, wr_strobe, wr_commit;
    logic [15:0] ptr_addr;
    logic [7:0]  wr_data;
    logic        sda_bus;

    logic [15:0] ptr;
    logic [7:0]  mem [256];
    logic [7:0]  rd_data;
    logic        prot_hit;
    int          n_inc = 0, n_wstb = 0, n_commit = 0, n_load = 0;
    logic [15:0] last_load = '0;
    logic        drove = 1'b0, clr_drove = 1'b0;

    int n_chk = 0, n_fail = 0;

    assign sda_bus  = m_sda & ~sda_low;
    assign rd_data  = mem[ptr[7:0]];
    assign prot_hit = prot_on && (ptr[7:0] >= 8'hC0);

    i2c_mem_target u_dut (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (m_scl),
        .sda_i       (sda_bus),
        .sda_low_o   (sda_low),
        .busy_i      (busy),
        .prot_hit_i  (prot_hit),
        .rd_data_i   (rd_data),
        .ptr_load_o  (ptr_load),
        .ptr_addr_o  (ptr_addr),
        .ptr_inc_o   (ptr_inc),
        .wr_strobe_o (wr_strobe),
        .wr_data_o   (wr_data),
        .wr_commit_o (wr_commit)
    );

    // pointer / memory model and strobe counters
    always @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
            for (int i = 0; i < 256; i++) mem[i] <= 8'hFF;
        end else begin
            if (ptr_load) begin
                ptr <= ptr_addr; n_load <= n_load + 1; last_load <= ptr_addr;
            end else if (ptr_inc) begin
                ptr <= ptr + 16'd1; n_inc <= n_inc + 1;
            end
            if (wr_strobe) begin
                mem[ptr[7:0]] <= wr_data; n_wstb <= n_wstb + 1;
            end
            if (wr_commit) n_commit <= n_commit + 1;
        end
        if (clr_drove) drove <= 1'b0;
        else if (sda_low) drove <= 1'b1;
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic qw; repeat (8) @(negedge clk); endtask

    task automatic b_start;
        m_sda = 1'b1; m_scl = 1'b1; qw;
        m_sda = 1'b0; qw;
        m_scl = 1'b0; qw;
    endtask

    task automatic b_rstart;
        m_sda = 1'b1; qw;
        m_scl = 1'b1; qw;
        m_sda = 1'b0; qw;
        m_scl = 1'b0; qw;
    endtask

    task automatic b_stop;
        m_sda = 1'b0; qw;
        m_scl = 1'b1; qw;
        m_sda = 1'b1; qw;
    endtask

    task automatic b_send(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; qw;
            m_scl = 1'b1; qw; qw;
            m_scl = 1'b0; qw;
        end
        m_sda = 1'b1; qw;
        m_scl = 1'b1; qw;
        ack = !sda_bus; qw;
        m_scl = 1'b0; qw;
    endtask

    task automatic b_recv(input logic mack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qw;
            m_scl = 1'b1; qw;
            b[i] = sda_bus; qw;
            m_scl = 1'b0;
        end
        qw;
        m_sda = !mack; qw;
        m_scl = 1'b1; qw; qw;
        m_scl = 1'b0; qw;
        m_sda = 1'b1;
    endtask

    task automatic wr_one(input logic [7:0] h, input logic [7:0] l, input logic [7:0] d,
                          output logic dack);
        logic a;
        b_start; b_send(8'hA2, a); b_send(h, a); b_send(l, a); b_send(d, dack); b_stop;
    endtask

    task automatic sel_read(input logic [7:0] h, input logic [7:0] l, output logic [7:0] d);
        logic a;
        b_start; b_send(8'hA2, a); b_send(h, a); b_send(l, a);
        b_rstart; b_send(8'hA3, a); b_recv(1'b0, d); b_stop;
    endtask

    // {hi, lo, data, prot_on, exp_ack, exp_readback}
    localparam logic [33:0] VEC [6] = '{
        {8'h00, 8'h10, 8'hA5, 1'b0, 1'b1, 8'hA5},
        {8'h40, 8'h11, 8'h3C, 1'b0, 1'b1, 8'h3C},
        {8'h00, 8'hC4, 8'h77, 1'b1, 1'b0, 8'hFF},
        {8'h00, 8'hC4, 8'h77, 1'b0, 1'b1, 8'h77},
        {8'h80, 8'h05, 8'h0F, 1'b0, 1'b1, 8'h0F},
        {8'h00, 8'hBF, 8'h5A, 1'b1, 1'b1, 8'h5A}
    };

    logic done = 1'b0;

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic a, d0;
        logic [7:0] r;
        int c0, w0, i0, l0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        // R1 reset: idle, line released, no strobes
        check(!sda_low && !ptr_load && !ptr_inc && !wr_strobe && !wr_commit,
              "R1 reset idle", sda_low, 0);

        // table walk: R6/R7/R5/R11 write + selective readback
        for (int i = 0; i < 6; i++) begin
            prot_on = VEC[i][9];
            wr_one(VEC[i][33:26], VEC[i][25:18], VEC[i][17:10], d0);
            check(d0 == VEC[i][8], "R6/R7 data ack", d0, VEC[i][8]);
            prot_on = 1'b0;
            sel_read(VEC[i][33:26], VEC[i][25:18], r);
            check(r == VEC[i][7:0], "R11 selective readback", r, VEC[i][7:0]);
        end

        // R3 wrong target address
        clr_drove = 1'b1; @(negedge clk); clr_drove = 1'b0;
        b_start; b_send(8'hA4, a);
        check(!a, "R3 wrong address nack", a, 0);
        b_send(8'h00, a); b_stop;
        check(!drove, "R3 no drive after mismatch", drove, 0);

        // R4 busy polling
        busy = 1'b1;
        b_start; b_send(8'hA2, a); b_stop;
        check(!a, "R4 busy write nack", a, 0);
        b_start; b_send(8'hA3, a); b_stop;
        check(!a, "R4 busy read nack", a, 0);
        busy = 1'b0;
        b_start; b_send(8'hA3, a); b_recv(1'b0, r); b_stop;
        check(a, "R4 ack when idle", a, 1);

        // R5 bit 14 cleared, bit 15 kept
        b_start; b_send(8'hA2, a); b_send(8'h7F, a); b_send(8'h33, a); b_stop;
        check(last_load == 16'h3F33, "R5 pointer load value", last_load, 16'h3F33);
        // R8 address-only write: no commit
        c0 = n_commit;
        b_start; b_send(8'hA2, a); b_send(8'h00, a); b_send(8'h40, a); b_stop;
        repeat (4) @(negedge clk);
        check(n_commit == c0, "R8 no commit without data", n_commit, c0);

        // R6 page write of four bytes, one commit (R8)
        c0 = n_commit; w0 = n_wstb;
        b_start; b_send(8'hA2, a); b_send(8'h00, a); b_send(8'h30, a);
        b_send(8'h11, a); b_send(8'h22, a); b_send(8'h33, a); b_send(8'h44, a); b_stop;
        repeat (4) @(negedge clk);
        check(n_wstb - w0 == 4, "R6 write strobes", n_wstb - w0, 4);
        check(n_commit - c0 == 1, "R8 one commit", n_commit - c0, 1);

        // R7 protected-only write: no strobe, no commit
        prot_on = 1'b1; c0 = n_commit; w0 = n_wstb;
        wr_one(8'h00, 8'hD0, 8'h12, d0);
        repeat (4) @(negedge clk);
        prot_on = 1'b0;
        check(n_wstb == w0 && n_commit == c0, "R7 protected no strobe", n_wstb - w0, 0);

        // R9/R10/R11 sequential read from 0x30, repeated start gives no commit (R8)
        c0 = n_commit;
        b_start; b_send(8'hA2, a); b_send(8'h00, a); b_send(8'h30, a);
        b_rstart; b_send(8'hA3, a);
        i0 = n_inc;
        b_recv(1'b1, r); check(r == 8'h11, "R9 seq byte0", r, 8'h11);
        b_recv(1'b1, r); check(r == 8'h22, "R10 seq byte1", r, 8'h22);
        b_recv(1'b0, r); check(r == 8'h33, "R10 seq byte2", r, 8'h33);
        check(n_inc - i0 == 3, "R9 pointer advances", n_inc - i0, 3);
        clr_drove = 1'b1; @(negedge clk); clr_drove = 1'b0;
        b_recv(1'b1, r);
        check(r == 8'hFF && !drove, "R10 idle after master nack", r, 8'hFF);
        b_stop;
        check(n_commit == c0, "R8 no commit after read", n_commit, c0);

        // R11 immediate read at current pointer (0x33)
        b_start; b_send(8'hA3, a); b_recv(1'b0, r); b_stop;
        check(r == 8'h44, "R11 immediate read", r, 8'h44);

        // R1 start in mid-byte restarts at target address
        l0 = n_load;
        b_start;
        for (int i = 7; i >= 4; i--) begin
            m_sda = 1'(8'hA2 >> i); qw;
            m_scl = 1'b1; qw; qw;
            m_scl = 1'b0; qw;
        end
        b_rstart; b_send(8'hA3, a); b_recv(1'b0, r); b_stop;
        check(a, "R1 abort then address ack", a, 1);
        check(n_load == l0, "R1 aborted byte no load", n_load - l0, 0);
        check(!sda_low, "R2 line released at end", sda_low, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule